// File: doc/BRIEF.md
# DMA Request and Terminal Count Controller

This block drives the DMA request line of a peripheral data buffer and decides when a DMA run ends. A start command opens a run. The block then raises its request, and each cycle in which the acknowledge strobe is high while the request is up counts as one completed transfer. A two-bit mode input decides when the request drops and when it rises again. Single mode drops the request after every transfer. Burst mode holds it up. Timed programmable burst holds it for a fixed number of cycles. Counted programmable burst holds it for a fixed number of transfers.

In the two programmable-burst modes, a request that has dropped rises again on one of two triggers. The external trigger is a falling edge on the refresh input. The internal trigger is the end of a gate window of 350 ns or 750 ns, counted in clock cycles. With the external trigger, the first request of a run can also be made to wait for a refresh. A run ends on the external terminal-count input in every mode. In single and burst modes it can also end on an internal 9-bit transfer target. At the end, the request drops, the terminal-count pin pulses for one cycle and a done flag is set. Both pins have programmable polarity.

The FSM states are IDLE (waiting for start), WAIT_REF (start seen, waiting for the first refresh), REQ (request up), GAP (request down, waiting for re-assertion) and FINISH (one-cycle terminal pulse). Transitions:
- IDLE to REQ on start.
- IDLE to WAIT_REF on start, when waiting for a refresh is selected.
- WAIT_REF to REQ on a refresh fall.
- REQ to GAP at the end of a transfer or burst.
- GAP to REQ on the re-trigger.
- REQ, GAP or WAIT_REF to FINISH at terminal count.
- FINISH to IDLE always.

Top module: `dreq_ctrl`

## Requirements
- R1: While reset is held and after release, dreq_o sits at its inactive level (equal to req_pol_i), tc_o sits at its inactive level (equal to tc_pol_i), done_o is 0 and the block is idle.
- R2: Single mode (mode_i=00) asserts the request on the cycle after start_i. After each cycle in which dack_i is high with the request up, the request is negated for exactly one cycle and then asserted again, while the run continues.
- R3: Burst mode (mode_i=01) keeps the request asserted across transfers until the run ends.
- R4: In modes 00 and 01 with tc_src_i=1, the run ends on the transfer whose count equals the target {aux_i, tc_low_i}, where aux_i is bit 8. A target of 0 means 512 transfers.
- R5: In modes 00 and 01 with tc_src_i=0, the internal target is ignored and only the external terminal count ends the run.
- R6: A rising edge on ext_tc_i (active high) ends the run in any mode. It passes through two synchronizer flops, and tc_o becomes active on the third clock edge after the input rises.
- R7: Counted programmable burst (mode_i=11) negates the request after BURST_XFERS transfers (default 8).
- R8: Timed programmable burst (mode_i=10) negates the request after it has been asserted for HOLD_CYCLES cycles (default 8).
- R9: In modes 10 and 11 with tc_src_i=0, a negated request is re-asserted on the third clock edge after a falling edge on refresh_n_i. Without such an edge it stays negated.
- R10: In modes 10 and 11 with tc_src_i=1, the request stays negated for exactly the gate window. At 20 MHz this is 7 cycles with aux_i=0 (350 ns) and 15 cycles with aux_i=1 (750 ns).
- R11: In modes 10 and 11 with tc_src_i=0, aux_i=1 holds back the first request until a refresh falling edge. aux_i=0 asserts it on the cycle after start.
- R12: dreq_o equals the active request XOR req_pol_i. tc_o equals the active terminal pulse XOR tc_pol_i.
- R13: At the end of a run the request drops, tc_o is active for exactly one cycle, and done_o rises the next cycle. done_o stays high until the next start_i clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 2 | Transfer mode: 00 single, 01 burst, 10 timed burst, 11 counted burst |
| tc_src_i | input | 1 | Modes 00/01: enable internal target. Modes 10/11: re-trigger source (0 refresh, 1 gate timer) |
| aux_i | input | 1 | Modes 00/01: target bit 8. External re-trigger: wait for refresh at start. Internal re-trigger: long gate |
| tc_low_i | input | 8 | Target bits 7..0 |
| tc_pol_i | input | 1 | 1 makes tc_o active low |
| req_pol_i | input | 1 | 1 makes dreq_o active low |
| dack_i | input | 1 | Transfer acknowledge strobe, one transfer per high cycle |
| ext_tc_i | input | 1 | Asynchronous external terminal count, active high |
| refresh_n_i | input | 1 | Asynchronous refresh input, falling edge triggers |
| dreq_o | output | 1 | DMA request pin |
| tc_o | output | 1 | Terminal count pin |
| done_o | output | 1 | Run finished flag |

## Verification
The assertions assume that mode_i, tc_src_i, aux_i, tc_low_i and both polarity bits stay constant from start_i until the run has ended. They also assume dack_i is raised only while the request is up. The bench changes configuration only while the block is idle, and it raises the acknowledge only on clock cycles in which it has just sampled the request as active. Both asynchronous inputs are held for several cycles around each edge so that the synchronizers see clean levels.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
    typedef enum logic [1:0] {
        XM_SINGLE  = 2'b00,
        XM_BURST   = 2'b01,
        XM_TIMED   = 2'b10,
        XM_COUNTED = 2'b11
    } xfer_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_REF,
        S_REQ,
        S_GAP,
        S_FINISH
    } dreq_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int              W        = 2,
    parameter logic [W-1:0]    INIT     = '0,
    parameter logic [W-1:0]    FALL_SEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] edge_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic ff1, ff2, prev;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ff1  <= INIT[i];
                ff2  <= INIT[i];
                prev <= INIT[i];
            end else begin
                ff1  <= d[i];
                ff2  <= ff1;
                prev <= ff2;
            end
        end
        if (FALL_SEL[i]) begin : g_fall
            assign edge_o[i] = prev & ~ff2;
        end else begin : g_rise
            assign edge_o[i] = ff2 & ~prev;
        end
    end
endmodule

// File: rtl/dreq_gate_timer.sv
module dreq_gate_timer #(
    parameter int CLK_KHZ  = 20000,
    parameter int SHORT_NS = 350,
    parameter int LONG_NS  = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic expired
);
    localparam int G_SHORT = (SHORT_NS * CLK_KHZ + 999_999) / 1_000_000;
    localparam int G_LONG  = (LONG_NS  * CLK_KHZ + 999_999) / 1_000_000;
    localparam int GW      = $clog2(G_LONG + 1);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= long_sel ? GW'(G_LONG - 1) : GW'(G_SHORT - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R10: a loaded window counts down one step per cycle
    a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dreq_xfer_counter.sv
module dreq_xfer_counter #(
    parameter int TCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           inc,
    input  logic [TCW-1:0] target,
    output logic           hit
);
    logic [TCW-1:0] cnt;
    logic [TCW-1:0] cnt_nxt;

    assign cnt_nxt = cnt + 1'b1;
    assign hit     = inc && (cnt_nxt == target);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt_nxt;
    end

    // R4: the count holds between transfers
    a_r4_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
    import dreq_pkg::*;
#(
    parameter int CLK_KHZ     = 20000,
    parameter int LOW_W       = 8,
    parameter int HOLD_CYCLES = 8,
    parameter int BURST_XFERS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             tc_src_i,
    input  logic             aux_i,
    input  logic [LOW_W-1:0] tc_low_i,
    input  logic             tc_pol_i,
    input  logic             req_pol_i,
    input  logic             dack_i,
    input  logic             ext_tc_i,
    input  logic             refresh_n_i,
    output logic             dreq_o,
    output logic             tc_o,
    output logic             done_o
);
    localparam int TCW  = LOW_W + 1;
    localparam int BMAX = (HOLD_CYCLES > BURST_XFERS) ? HOLD_CYCLES : BURST_XFERS;
    localparam int BW   = $clog2(BMAX + 1);

    dreq_state_e state, nxt;
    xfer_mode_e  mode;
    logic        prog;
    logic [1:0]  edge_v;
    logic        ext_rise, ref_fall;
    logic        hit, itc_hit, tmr_exp, enter_gap, start_acc;
    logic        req_act, tc_act, done_q;
    logic [BW-1:0] bcnt;

    assign mode      = xfer_mode_e'(mode_i);
    assign prog      = mode_i[1];
    assign start_acc = (state == S_IDLE) && start_i;

    dreq_sync #(.W(2), .INIT(2'b10), .FALL_SEL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({refresh_n_i, ext_tc_i}), .edge_o(edge_v)
    );
    assign ext_rise = edge_v[0];
    assign ref_fall = edge_v[1];

    dreq_xfer_counter #(.TCW(TCW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .inc((state == S_REQ) && dack_i),
        .target({aux_i, tc_low_i}), .hit(hit)
    );
    assign itc_hit = !prog && tc_src_i && hit;

    dreq_gate_timer #(.CLK_KHZ(CLK_KHZ)) u_gate (
        .clk(clk), .rst_n(rst_n), .load(enter_gap),
        .long_sel(aux_i), .expired(tmr_exp)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:
                if (start_i)
                    nxt = (prog && !tc_src_i && aux_i) ? S_WAIT_REF : S_REQ;
            S_WAIT_REF:
                if (ext_rise)      nxt = S_FINISH;
                else if (ref_fall) nxt = S_REQ;
            S_REQ:
                if (ext_rise || itc_hit) nxt = S_FINISH;
                else begin
                    unique case (mode)
                        XM_SINGLE:  if (dack_i) nxt = S_GAP;
                        XM_BURST:   nxt = S_REQ;
                        XM_TIMED:   if (bcnt == BW'(HOLD_CYCLES - 1)) nxt = S_GAP;
                        XM_COUNTED: if (dack_i && bcnt == BW'(BURST_XFERS - 1)) nxt = S_GAP;
                        default:    nxt = S_REQ;
                    endcase
                end
            S_GAP:
                if (ext_rise)                         nxt = S_FINISH;
                else if (!prog)                       nxt = S_REQ;
                else if (tc_src_i ? tmr_exp : ref_fall) nxt = S_REQ;
            S_FINISH:
                nxt = S_IDLE;
            default:
                nxt = S_IDLE;
        endcase
    end

    assign enter_gap = (state == S_REQ) && (nxt == S_GAP);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || nxt != S_REQ || state != S_REQ)
            bcnt <= '0;
        else if (mode == XM_TIMED || (mode == XM_COUNTED && dack_i))
            bcnt <= bcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) done_q <= 1'b0;
        else if (state == S_FINISH) done_q <= 1'b1;
    end

    always_comb begin
        req_act = (state == S_REQ);
        tc_act  = (state == S_FINISH);
        dreq_o  = req_act ^ req_pol_i;
        tc_o    = tc_act ^ tc_pol_i;
        done_o  = done_q;
    end

    a_r2_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_act && dack_i && mode_i == 2'b00) |=> !req_act);
    a_r3_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_act && mode_i == 2'b01 && !ext_rise && !itc_hit) |=> req_act);
    a_r11_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && prog && !tc_src_i && aux_i) |=> !req_act);
    a_r13_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc_act |=> !tc_act);
    a_r13_done_after: assert property (@(posedge clk) disable iff (!rst_n)
        tc_act |=> done_q);
    a_r13_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !done_q);
endmodule

// File: tb/dreq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dreq_ctrl_tb_top;
    localparam int CLK_PERIOD = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       tc_src_i = 1'b0, aux_i = 1'b0;
    logic [7:0] tc_low_i = 8'd0;
    logic       tc_pol_i = 1'b0, req_pol_i = 1'b0;
    logic       dack_i = 1'b0, ext_tc_i = 1'b0, refresh_n_i = 1'b1;
    logic       dreq_o, tc_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dreq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .tc_src_i(tc_src_i), .aux_i(aux_i), .tc_low_i(tc_low_i),
        .tc_pol_i(tc_pol_i), .req_pol_i(req_pol_i), .dack_i(dack_i),
        .ext_tc_i(ext_tc_i), .refresh_n_i(refresh_n_i),
        .dreq_o(dreq_o), .tc_o(tc_o), .done_o(done_o)
    );

    // {mode, tc_src, aux, low, tc_pol, req_pol, expected transfers}
    localparam logic [23:0] VEC [6] = '{
        {2'b00, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 10'd3},
        {2'b01, 1'b1, 1'b0, 8'd5, 1'b0, 1'b0, 10'd5},
        {2'b00, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 10'd1},
        {2'b01, 1'b1, 1'b1, 8'd2, 1'b0, 1'b0, 10'd258},
        {2'b00, 1'b1, 1'b0, 8'd4, 1'b1, 1'b1, 10'd4},
        {2'b01, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 10'd512}
    };

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic config_run(input logic [1:0] m, input logic s, input logic a, input logic [7:0] lo);
        mode_i = m; tc_src_i = s; aux_i = a; tc_low_i = lo;
    endtask

    task automatic pulse_start;
        start_i = 1'b1; tick; start_i = 1'b0;
    endtask

    task automatic count_active(output int n, input bit ack);
        n = 0;
        while (dreq_o != req_pol_i && n < 1000) begin
            dack_i = ack; n++; tick;
        end
        dack_i = 1'b0;
    endtask

    task automatic count_inactive(output int g);
        g = 0;
        while (dreq_o == req_pol_i && g < 1000) begin
            g++; tick;
        end
    endtask

    task automatic end_run;
        ext_tc_i = 1'b1; repeat (5) tick;
        ext_tc_i = 1'b0; repeat (3) tick;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, g, tcw;
        bit seen;
        repeat (3) tick;
        chk("R1 dreq in reset", dreq_o, 0);
        chk("R1 tc in reset", tc_o, 0);
        rst_n = 1'b1; tick;
        chk("R1 done after reset", done_o, 0);
        chk("R1 dreq after reset", dreq_o, 0);

        // vector table: runs ended by the internal target
        for (int v = 0; v < 6; v++) begin
            config_run(VEC[v][23:22], VEC[v][21], VEC[v][20], VEC[v][19:12]);
            tc_pol_i = VEC[v][11]; req_pol_i = VEC[v][10];
            tick;
            chk("R12 idle dreq level", dreq_o, req_pol_i);
            chk("R12 idle tc level", tc_o, tc_pol_i);
            pulse_start;
            n = 0; tcw = 0; seen = 0;
            for (int k = 0; k < 2000; k++) begin
                if (tc_o != tc_pol_i) begin tcw++; seen = 1; end
                else if (seen) break;
                if (dreq_o != req_pol_i) begin dack_i = 1'b1; n++; end
                else dack_i = 1'b0;
                tick;
            end
            dack_i = 1'b0;
            chk("R4 transfers to target", n, int'(VEC[v][9:0]));
            chk("R13 tc pulse width", tcw, 1);
            chk("R13 done set", done_o, 1);
            chk("R13 dreq dropped", dreq_o, req_pol_i);
        end
        tc_pol_i = 1'b0; req_pol_i = 1'b0; tick;

        // R2 single-mode timing, R5 target ignored, R6 external end
        config_run(2'b00, 1'b0, 1'b0, 8'd2);
        pulse_start;
        chk("R13 start clears done", done_o, 0);
        chk("R2 request after start", dreq_o, 1);
        dack_i = 1'b1; tick; dack_i = 1'b0;
        chk("R2 one-cycle gap", dreq_o, 0);
        tick;
        chk("R2 re-asserted", dreq_o, 1);
        for (int k = 0; k < 3; k++) begin
            dack_i = 1'b1; tick; dack_i = 1'b0; tick;
        end
        chk("R5 target ignored dreq", dreq_o, 1);
        chk("R5 target ignored done", done_o, 0);
        ext_tc_i = 1'b1;
        tick; tick;
        chk("R6 tc not yet", tc_o, 0);
        tick;
        chk("R6 tc on third edge", tc_o, 1);
        tick;
        chk("R6 tc one cycle", tc_o, 0);
        chk("R6 done", done_o, 1);
        ext_tc_i = 1'b0;
        repeat (5) tick;
        chk("R13 done holds", done_o, 1);

        // R7 counted burst, R10 short gate
        config_run(2'b11, 1'b1, 1'b0, 8'd0);
        pulse_start;
        count_active(n, 1'b1);
        chk("R7 transfers per burst", n, 8);
        count_inactive(g);
        chk("R10 short gate", g, 7);
        count_active(n, 1'b1);
        chk("R7 second burst", n, 8);
        end_run;

        // R8 timed burst, R10 long gate
        config_run(2'b10, 1'b1, 1'b1, 8'd0);
        pulse_start;
        count_active(n, 1'b0);
        chk("R8 hold cycles", n, 8);
        count_inactive(g);
        chk("R10 long gate", g, 15);
        end_run;

        // R11 wait for refresh, R9 refresh re-trigger
        config_run(2'b11, 1'b0, 1'b1, 8'd0);
        pulse_start;
        repeat (5) tick;
        chk("R11 held until refresh", dreq_o, 0);
        refresh_n_i = 1'b0;
        tick; tick;
        chk("R9 not yet", dreq_o, 0);
        tick;
        chk("R11 request after refresh", dreq_o, 1);
        refresh_n_i = 1'b1;
        count_active(n, 1'b1);
        chk("R7 burst before refresh", n, 8);
        repeat (10) tick;
        chk("R9 no retrigger without edge", dreq_o, 0);
        refresh_n_i = 1'b0;
        repeat (3) tick;
        chk("R9 retrigger on fall", dreq_o, 1);
        refresh_n_i = 1'b1;
        end_run;

        // R11 immediate start, R3 burst hold
        config_run(2'b11, 1'b0, 1'b0, 8'd0);
        pulse_start;
        chk("R11 immediate request", dreq_o, 1);
        end_run;
        config_run(2'b01, 1'b0, 1'b0, 8'd0);
        pulse_start;
        count_active(n, 1'b1);
        chk("R3 burst held until end", n, 1000);
        end_run;
        chk("R3 ended by external", done_o, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule